// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the two timing strobes that one serial channel needs: a sample tick that paces the receiver's oversampling and a bit tick that marks each bit interval. Both come from a single reference clock. The clock is first optionally divided by four. A divisor then follows, made of an integer part and a 4-bit fractional part. The fractional part lengthens some sample periods by one prescaled clock. These longer periods are spread evenly so that the average rate matches the programmed value exactly.

Oversampling is selectable at run time: either 16 or 8 sample ticks make up one bit. The 8X setting doubles the highest bit rate available from a given reference clock. The configuration pins may change at any time. Any change restarts every counter, and the new setting then runs as if it had just left reset. No partial or doubled tick appears at the changeover. A divisor of zero parks the generator with both strobes low.

Top module: `frac_baud_gen`

## Requirements
- R1: When `pre_div4_i` is 1, a sample tick can only occur on every fourth reference clock (cycles 3, 7, 11, ... after a restart), so two sample ticks are never adjacent. When it is 0, every reference clock counts.
- R2: With `div_frac_i` = 0, sample ticks are spaced exactly `div_int_i` prescaled clocks apart.
- R3: With integer part D and fractional value F, sample period j (counting from 1 after a restart) ends after a total of j*D + floor(j*F/16) prescaled clocks. Any 16 consecutive periods from a restart therefore take 16*D+F clocks.
- R4: `os8_mode_i` = 1 selects 8X oversampling and 0 selects 16X. The bit tick is asserted on every 8th or 16th sample tick respectively, counted from a restart.
- R5: With prescaler 1, D = 1 and F = 0, the bit tick comes every 8 reference clocks in 8X mode and every 16 in 16X mode.
- R6: A `div_int_i` of 0 keeps both ticks low for as long as it is applied.
- R7: The bit tick is a single-cycle strobe and is only ever asserted in a cycle that also carries a sample tick.
- R8: A change on any configuration input restarts the counters at the next clock edge. The first tick of the new setting arrives exactly one full new period after that edge. With prescale by 4, no sample tick occurs in the first cycle after the restart.
- R9: While `rst_n` is low, both ticks are low. After release, the first sample tick comes in the cycle that completes one full period (cycle ps*P-1, where cycle 0 is the first cycle with reset high, ps is 1 or 4 and P is the first period length).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pre_div4_i | input | 1 | 1: divide reference clock by 4 before the divisor; 0: by 1 |
| os8_mode_i | input | 1 | 1: 8 samples per bit; 0: 16 samples per bit |
| div_int_i | input | DIV_W | Integer part of the divisor (0 stops the ticks) |
| div_frac_i | input | FRAC_W | Fractional part of the divisor, in sixteenths |
| sample_tick_o | output | 1 | Oversampling strobe, one reference clock wide |
| bit_tick_o | output | 1 | Bit-interval strobe, one reference clock wide |

## Verification
The main sweep covers every fractional value from 0 to 15, combined with several integer divisors, both prescaler settings and both oversampling ratios. Each cycle's ticks are compared with the closed form j*D + floor(j*F/16). This tells a correct spread of the extra clocks apart from bunched or missing ones, and it catches an off-by-one in the period length or in the count of samples per bit. Each new setting is applied without a reset, so every run also checks the restart timing. Separate runs cover the zero divisor (no ticks at all), the two fastest rates at divisor 1 (bit spacing of 8 versus 16 clocks), and the first tick after reset release with prescale by 4.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic { OS_X16 = 1'b0, OS_X8 = 1'b1 } os_mode_e;

  localparam int unsigned PRE_W  = 2;   // prescale by 2**PRE_W when enabled
  localparam int unsigned SAMP_W = 4;   // enough for 16 samples per bit

  function automatic logic [SAMP_W-1:0] last_sample(input os_mode_e m);
    return (m == OS_X8) ? SAMP_W'(7) : SAMP_W'(15);
  endfunction
endpackage

// File: rtl/fbg_prescaler.sv
module fbg_prescaler
  import fbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic div4,
  output logic pre_en
);
  logic [PRE_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase_q <= '0;
    else                   phase_q <= phase_q + 1'b1;
  end

  assign pre_en = div4 ? (phase_q == {PRE_W{1'b1}}) : 1'b1;

  // R1: in divide-by-4 mode enables never come back to back
  p_pre_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (div4 && pre_en && !restart) |=> !pre_en || !div4);
endmodule

// File: rtl/fbg_frac_div.sv
module fbg_frac_div #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              pre_en,
  input  logic [DIV_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  logic [DIV_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic              stretch;
  logic              parked;
  logic [DIV_W-1:0]  last;

  assign parked  = (div_int == '0);
  assign acc_sum = {1'b0, acc_q} + {1'b0, div_frac};
  assign stretch = acc_sum[FRAC_W];
  assign last    = div_int - DIV_W'(1) + DIV_W'(stretch);
  assign tick    = pre_en && !parked && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (pre_en && !parked) begin
      if (cnt_q == last) begin
        cnt_q <= '0;
        acc_q <= acc_sum[FRAC_W-1:0];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3: the period counter never passes the end of the current period
  p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !parked |-> cnt_q <= last);
  // R6: a zero divisor leaves the counter where it was
  p_parked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !restart) |=> (cnt_q == $past(cnt_q)) || restart);
endmodule

// File: rtl/fbg_bit_div.sv
module fbg_bit_div
  import fbg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  os_mode_e mode,
  input  logic     samp,
  output logic     bit_tick
);
  logic [SAMP_W-1:0] idx_q;
  logic [SAMP_W-1:0] top;

  assign top      = last_sample(mode);
  assign bit_tick = samp && (idx_q == top);

  always_ff @(posedge clk) begin
    if (!rst_n || restart)  idx_q <= '0;
    else if (samp)          idx_q <= (idx_q == top) ? '0 : idx_q + 1'b1;
  end

  // R4: the sample index stays inside the selected ratio
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= top);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_div4_i,
  input  logic              os8_mode_i,
  input  logic [DIV_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              sample_tick_o,
  output logic              bit_tick_o
);
  localparam int unsigned CFG_W = 2 + DIV_W + FRAC_W;

  logic [CFG_W-1:0] cfg_in, cfg_q;
  logic             restart;
  logic             pre_en, samp_raw, bit_raw;
  os_mode_e         mode_q;

  assign cfg_in = {pre_div4_i, os8_mode_i, div_int_i, div_frac_i};

  // configuration is captured during reset and on every edge; a difference
  // between the pins and the captured copy restarts all counters
  always_ff @(posedge clk) cfg_q <= cfg_in;

  assign restart = rst_n && (cfg_in != cfg_q);
  assign mode_q  = os_mode_e'(cfg_q[CFG_W-2]);

  fbg_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .div4    (cfg_q[CFG_W-1]),
    .pre_en  (pre_en)
  );

  fbg_frac_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .pre_en   (pre_en),
    .div_int  (cfg_q[FRAC_W +: DIV_W]),
    .div_frac (cfg_q[FRAC_W-1:0]),
    .tick     (samp_raw)
  );

  fbg_bit_div u_bit (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .mode     (mode_q),
    .samp     (samp_raw),
    .bit_tick (bit_raw)
  );

  assign sample_tick_o = rst_n && samp_raw;
  assign bit_tick_o    = rst_n && bit_raw;

  // R6: zero divisor keeps the sample strobe low
  p_zero_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[FRAC_W +: DIV_W] == '0) |-> !sample_tick_o);
  // R7: a bit strobe always rides on a sample strobe
  p_bit_on_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |-> sample_tick_o);
  // R7: the bit strobe lasts a single cycle
  p_bit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |=> !bit_tick_o);
  // R8: after a restart into divide-by-4 no tick comes in the first cycle
  p_restart_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!cfg_q[CFG_W-1] || !sample_tick_o));
endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  localparam int DW = 16;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pre4 = 1'b0;
  logic          os8 = 1'b0;
  logic [DW-1:0] dint = '0;
  logic [FW-1:0] dfrac = '0;
  logic          s_tick, b_tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  frac_baud_gen #(.DIV_W(DW), .FRAC_W(FW)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pre_div4_i    (pre4),
    .os8_mode_i    (os8),
    .div_int_i     (dint),
    .div_frac_i    (dfrac),
    .sample_tick_o (s_tick),
    .bit_tick_o    (b_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs ncyc cycles starting at cycle 0 of the current setting (caller is at
  // the negedge of cycle 0). Compares each cycle with the closed form.
  task automatic stream(input string req, input int ncyc,
                        output int n_samp, output int n_bit);
    int psf = pre4 ? 4 : 1;
    int nr  = os8 ? 8 : 16;
    int d   = int'(dint);
    int f   = int'(dfrac);
    int j   = 1;
    int miss_s = 0, miss_b = 0;
    int first_bad = -1;
    n_samp = 0;
    n_bit  = 0;
    for (int n = 0; n < ncyc; n++) begin
      int es = 0, eb = 0;
      if (d != 0 && ((n + 1) % psf) == 0) begin
        int k = (n + 1) / psf;
        if (k == j * d + (j * f) / 16) begin
          es = 1;
          eb = ((j % nr) == 0) ? 1 : 0;
          j++;
        end
      end
      if (int'(s_tick) != es) begin miss_s++; if (first_bad < 0) first_bad = n; end
      if (int'(b_tick) != eb) begin miss_b++; if (first_bad < 0) first_bad = n; end
      n_samp += int'(s_tick);
      n_bit  += int'(b_tick);
      @(negedge clk);
    end
    if (miss_s != 0 || miss_b != 0)
      $display("  setting pre4=%0d os8=%0d D=%0d F=%0d first mismatch cycle %0d",
               pre4, os8, d, f, first_bad);
    check({req, " sample timing"}, miss_s, 0);
    check({req, " bit timing"}, miss_b, 0);
  endtask

  // apply a new setting at a negedge and move to its cycle 0
  task automatic apply(input logic p4, input logic o8, input int d, input int f);
    pre4  = p4;
    os8   = o8;
    dint  = DW'(d);
    dfrac = FW'(f);
    @(negedge clk);
  endtask

  initial begin
    int ns, nb;
    // R9: outputs held low in reset even with a setting that ticks every cycle
    pre4 = 1'b0; os8 = 1'b1; dint = 16'd1; dfrac = '0;
    repeat (3) @(negedge clk);
    check("R9 sample low in reset", int'(s_tick), 0);
    check("R9 bit low in reset", int'(b_tick), 0);
    // R9: first tick after release with prescale 4, D=3 -> cycle 11
    pre4 = 1'b1; dint = 16'd3;
    @(negedge clk);
    rst_n = 1'b1;
    stream("R9 after reset", 200, ns, nb);

    // R5: fastest rates at D=1
    apply(1'b0, 1'b1, 1, 0);
    stream("R5 8X D=1", 160, ns, nb);
    check("R5 8X bit ticks in 160 clocks", nb, 20);
    apply(1'b0, 1'b0, 1, 0);
    stream("R5 16X D=1", 160, ns, nb);
    check("R5 16X bit ticks in 160 clocks", nb, 10);

    // R3: 16 periods of D=2, F=5 take exactly 37 clocks
    apply(1'b0, 1'b0, 2, 5);
    stream("R3 D=2 F=5", 37, ns, nb);
    check("R3 sample ticks in 37 clocks", ns, 16);

    // R6: zero divisor gives no ticks, then recovers on a new divisor
    apply(1'b0, 1'b1, 0, 7);
    stream("R6 zero divisor", 200, ns, nb);
    check("R6 no sample ticks", ns, 0);
    apply(1'b0, 1'b1, 3, 0);
    stream("R8 recover after zero", 60, ns, nb);

    // R1 R2 R3 R4 R8: sweep, each setting entered by restart, no reset
    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 2; o++)
        for (int di = 0; di < 4; di++)
          for (int f = 0; f < 16; f++) begin
            int d = (di == 3) ? 7 : di + 1;
            apply(p[0], o[0], d, f);
            stream("R1 R2 R3 R4 R8 sweep", 17 * (d + 1) * (p != 0 ? 4 : 1) + 4, ns, nb);
          end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<195000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule